// File: doc/BRIEF.md
# Stop-Mode Power-Down Controller

This block decides when a small microcontroller core is allowed to halt its oscillator, and how it comes back. Software enters stop mode by setting a single control bit in a power-control register. That write is honoured only inside a short timed-access window, which a two-byte key sequence opens. Once stop mode is entered, the oscillator enable drops. This stops the CPU, the peripheral clocks and the watchdog together. Nothing on the write bus can wake the device again.

Only a reset brings the device back: either the external reset pin or a power-on reset. Each time reset is released, the controller holds the core in reset for a fixed oscillator start-up count, which defaults to 21,504 clocks. At the start of that hold it emits a one-cycle strobe that tells the core to reload every register a reset initialises. The controller runs on a free-running reference clock. Its start-up counter advances only while the oscillator enable is high. Both resets are treated as synchronous to the reference clock and active high.

Top module: `stopctl`

## Requirements
- R1: While `por` is high, `core_rst`=1, `osc_en`=1, `wdt_en`=0 and `sfr_init`=0, and the stop bit is cleared.
- R2: The stop control is bit 1 of the register at address `CTRL_ADDR`. A write there inside an open timed-access window loads that bit. When the bit becomes 1, `osc_en` and `wdt_en` are low from the next clock on. A written 0 leaves the oscillator running.
- R3: The window opens when the bus writes 0xAA to `UNLOCK_ADDR` and the next bus write is 0x55 to the same address. A control write is then accepted on clock edges 1 to `UNLOCK_WIN` after the 0x55 write, and on no other edge. Any other write between the two key bytes cancels the sequence.
- R4: Any write to `CTRL_ADDR` closes an open window, whatever value it carries. Control writes made outside a window change nothing.
- R5: Once stopped, `osc_en` stays low until `ext_rst` or `por` is high. Bus writes made while stopped have no effect.
- R6: `wdt_en` is high only while `osc_en` is high and `core_rst` is low.
- R7: Each reset release (`ext_rst` or `por`) is followed by exactly `HOLD_CYCLES` clock edges with `core_rst` high before it falls. `osc_en` is high throughout this hold. `HOLD_CYCLES` is at least 2.
- R8: `sfr_init` is high for exactly one cycle in each hold, after the first counting edge. It is never high while `core_rst` is low.
- R9: If reset is raised again during a hold, the count restarts from zero. The full `HOLD_CYCLES` then applies from the new release.
- R10: Bus writes made while `core_rst` is high are ignored, including key bytes and control writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External reset pin, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| osc_en | output | 1 | Oscillator enable, low in stop mode |
| wdt_en | output | 1 | Watchdog clock enable |
| core_rst | output | 1 | Reset held on the core |
| sfr_init | output | 1 | One-cycle strobe to reload reset-initialised registers |

## Verification
Every value of the control byte is written both with the window open and with it closed. The accepted writes show that only bit 1 selects stop; the unprotected writes show that no value gets through without the key. The gap between the second key byte and the control write is swept across and past the window length, which locates both edges of the window. Broken key sequences, a write that consumes the window, writes made while stopped and writes made during the hold separate the ignore paths from one another. Hold lengths are measured after pin exits, power-on exits and a reset reasserted mid-hold, which distinguishes a restart of the count from a continuation.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    // Timed-access key bytes, written in this order to the unlock register
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    // Position of the stop control inside the power-control register
    localparam int STOP_BIT = 1;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_e;

    typedef enum logic {
        HOLD_COUNT,
        HOLD_RUN
    } hold_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } bus_wr_t;

    // Bits needed to hold values 0..n
    function automatic int width_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/stopctl_unlock.sv
module stopctl_unlock
    import stopctl_pkg::*;
#(
    parameter logic [7:0] UNLOCK_ADDR = 8'h3B,
    parameter logic [7:0] CTRL_ADDR   = 8'h3A,
    parameter int         UNLOCK_WIN  = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    output logic    unlocked
);

    localparam int              WW       = width_for(UNLOCK_WIN);
    localparam logic [WW-1:0]   WIN_LOAD = WW'(UNLOCK_WIN);
    localparam logic [WW-1:0]   WIN_STEP = WW'(1);

    key_state_e      key_q;
    logic [WW-1:0]   win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= KEY_IDLE;
            win_q <= '0;
        end else begin
            if (win_q != '0) begin
                win_q <= win_q - WIN_STEP;
            end
            if (wr.en) begin
                if (wr.addr == UNLOCK_ADDR) begin
                    if (key_q == KEY_ARMED && wr.data == KEY_SECOND) begin
                        win_q <= WIN_LOAD;
                        key_q <= KEY_IDLE;
                    end else if (wr.data == KEY_FIRST) begin
                        key_q <= KEY_ARMED;
                    end else begin
                        key_q <= KEY_IDLE;
                    end
                end else begin
                    key_q <= KEY_IDLE;
                    if (wr.addr == CTRL_ADDR) begin
                        win_q <= '0;
                    end
                end
            end
        end
    end

    assign unlocked = (win_q != '0);

endmodule

// File: rtl/stopctl_pcon.sv
module stopctl_pcon (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic unlocked,
    input  logic stop_val,
    output logic stop_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
        end else if (ctrl_wr && unlocked) begin
            stop_q <= stop_val;
        end
    end

endmodule

// File: rtl/stopctl_hold.sv
module stopctl_hold
    import stopctl_pkg::*;
#(
    parameter int HOLD_CYCLES = 21504
) (
    input  logic clk,
    input  logic rst_in,
    input  logic osc_en,
    output logic core_rst,
    output logic sfr_init
);

    localparam int            CW   = $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    hold_state_e    st_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst_in) begin
            st_q  <= HOLD_COUNT;
            cnt_q <= '0;
        end else if (st_q == HOLD_COUNT && osc_en) begin
            if (cnt_q == LAST) begin
                st_q <= HOLD_RUN;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign core_rst = (st_q == HOLD_COUNT);
    assign sfr_init = (st_q == HOLD_COUNT) && (cnt_q == ONE);

endmodule

// File: rtl/stopctl.sv
module stopctl
    import stopctl_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR   = 8'h3A,
    parameter logic [7:0] UNLOCK_ADDR = 8'h3B,
    parameter int         UNLOCK_WIN  = 4,
    parameter int         HOLD_CYCLES = 21504
) (
    input  logic       clk,
    input  logic       por,
    input  logic       ext_rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       osc_en,
    output logic       wdt_en,
    output logic       core_rst,
    output logic       sfr_init
);

    logic    any_rst;
    logic    stop_q;
    logic    unlocked;
    logic    ctrl_wr;
    bus_wr_t bus;

    assign any_rst = por | ext_rst;

    // A halted or resetting core issues no bus cycles
    assign bus.en   = wr_en & ~stop_q & ~core_rst;
    assign bus.addr = wr_addr;
    assign bus.data = wr_data;
    assign ctrl_wr  = bus.en && (bus.addr == CTRL_ADDR);

    stopctl_unlock #(
        .UNLOCK_ADDR (UNLOCK_ADDR),
        .CTRL_ADDR   (CTRL_ADDR),
        .UNLOCK_WIN  (UNLOCK_WIN)
    ) u_unlock (
        .clk      (clk),
        .rst      (any_rst),
        .wr       (bus),
        .unlocked (unlocked)
    );

    stopctl_pcon u_pcon (
        .clk      (clk),
        .rst      (any_rst),
        .ctrl_wr  (ctrl_wr),
        .unlocked (unlocked),
        .stop_val (bus.data[STOP_BIT]),
        .stop_q   (stop_q)
    );

    stopctl_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk      (clk),
        .rst_in   (any_rst),
        .osc_en   (osc_en),
        .core_rst (core_rst),
        .sfr_init (sfr_init)
    );

    assign osc_en = ~stop_q;
    assign wdt_en = osc_en & ~core_rst;

endmodule

// File: rtl/stopctl_chk.sv
module stopctl_chk #(
    parameter logic [7:0] CTRL_ADDR = 8'h3A
) (
    input logic       clk,
    input logic       por,
    input logic       ext_rst,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       stop_req,
    input logic       osc_en,
    input logic       wdt_en,
    input logic       core_rst,
    input logic       sfr_init
);

    // R1
    por_release_chk: assert property (@(posedge clk) disable iff (por)
        $fell(por) |-> (core_rst && osc_en && !wdt_en));

    // R2
    stop_entry_chk: assert property (@(posedge clk) disable iff (por)
        $fell(osc_en) |-> $past(wr_en && wr_addr == CTRL_ADDR && stop_req));

    // R5
    stop_sticky_chk: assert property (@(posedge clk) disable iff (por)
        (!osc_en && !ext_rst) |=> !osc_en);

    // R6
    wdt_gate_chk: assert property (@(posedge clk) disable iff (por)
        (!osc_en || core_rst) |-> !wdt_en);

    // R7
    pin_wake_chk: assert property (@(posedge clk) disable iff (por)
        ext_rst |=> (core_rst && osc_en));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (por)
        sfr_init |=> !sfr_init);

    // R8
    strobe_in_hold_chk: assert property (@(posedge clk) disable iff (por)
        sfr_init |-> core_rst);

endmodule

bind stopctl stopctl_chk #(
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk      (clk),
    .por      (por),
    .ext_rst  (ext_rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .stop_req (wr_data[1]),
    .osc_en   (osc_en),
    .wdt_en   (wdt_en),
    .core_rst (core_rst),
    .sfr_init (sfr_init)
);

// File: tb/stopctl_test.sv
`timescale 1ns/1ps
module stopctl_test;

    localparam logic [7:0] CTRL = 8'h3A;
    localparam logic [7:0] UNL  = 8'h3B;
    localparam int         WIN  = 4;
    localparam int         HOLD = 24;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       osc_en, wdt_en, core_rst, sfr_init;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    stopctl #(
        .CTRL_ADDR   (CTRL),
        .UNLOCK_ADDR (UNL),
        .UNLOCK_WIN  (WIN),
        .HOLD_CYCLES (HOLD)
    ) uut (
        .clk      (clk),
        .por      (por),
        .ext_rst  (ext_rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .osc_en   (osc_en),
        .wdt_en   (wdt_en),
        .core_rst (core_rst),
        .sfr_init (sfr_init)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write is captured at the following posedge
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic unlock();
        bus_write(UNL, 8'hAA);
        bus_write(UNL, 8'h55);
    endtask

    // Called at the negedge where reset was just dropped
    task automatic measure_hold(input string req);
        int n = 0;
        int pulses = 0;
        int osc_low = 0;
        while (core_rst && n < HOLD + 10) begin
            @(negedge clk);
            n++;
            if (sfr_init) pulses++;
            if (core_rst && !osc_en) osc_low++;
        end
        chk({req, " R7 hold length"}, n, HOLD);
        chk({req, " R8 strobe count"}, pulses, 1);
        chk({req, " R7 osc during hold"}, osc_low, 0);
        chk({req, " R6 wdt after hold"}, int'(wdt_en), 1);
    endtask

    task automatic pin_reset(input string req);
        ext_rst = 1'b1;
        idle(2);
        chk({req, " R7 core_rst in reset"}, int'(core_rst), 1);
        ext_rst = 1'b0;
        measure_hold(req);
    endtask

    initial begin
        @(negedge clk);
        idle(3);
        // R1 reset state
        chk("R1 core_rst", int'(core_rst), 1);
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 wdt_en", int'(wdt_en), 0);
        chk("R1 sfr_init", int'(sfr_init), 0);
        por = 1'b0;
        measure_hold("R1 por exit");

        // R4: every control byte without unlock leaves the oscillator running
        for (int v = 0; v < 256; v++) begin
            bus_write(CTRL, 8'(v));
            chk("R4 unprotected write", int'(osc_en), 1);
        end

        // R2: every control byte with unlock; stop iff bit 1 set
        for (int v = 0; v < 256; v++) begin
            unlock();
            bus_write(CTRL, 8'(v));
            chk("R2 stop bit decode", int'(osc_en), ((v >> 1) & 1) ? 0 : 1);
            if (!osc_en) begin
                chk("R2 wdt off in stop", int'(wdt_en), 0);
                pin_reset("R2 exit");
            end
        end

        // R3: window edges, control write d edges after the second key
        for (int d = 1; d <= WIN + 2; d++) begin
            unlock();
            idle(d - 1);
            bus_write(CTRL, 8'h02);
            chk("R3 window edge", int'(osc_en), (d <= WIN) ? 0 : 1);
            if (!osc_en) pin_reset("R3 exit");
        end

        // R3: interrupted key sequences
        bus_write(UNL, 8'hAA);
        bus_write(8'h12, 8'h00);
        bus_write(UNL, 8'h55);
        bus_write(CTRL, 8'h02);
        chk("R3 broken by other address", int'(osc_en), 1);
        bus_write(UNL, 8'hAA);
        bus_write(UNL, 8'h11);
        bus_write(UNL, 8'h55);
        bus_write(CTRL, 8'h02);
        chk("R3 broken by wrong key", int'(osc_en), 1);
        bus_write(UNL, 8'h55);
        bus_write(UNL, 8'hAA);
        bus_write(CTRL, 8'h02);
        chk("R3 keys reversed", int'(osc_en), 1);

        // R4: a control write consumes the window
        unlock();
        bus_write(CTRL, 8'h00);
        bus_write(CTRL, 8'h02);
        chk("R4 window consumed", int'(osc_en), 1);

        // R5: stop is sticky; writes and waiting do not wake it
        unlock();
        bus_write(CTRL, 8'h02);
        chk("R5 entered stop", int'(osc_en), 0);
        idle(HOLD * 3);
        chk("R5 still stopped after wait", int'(osc_en), 0);
        unlock();
        bus_write(CTRL, 8'h00);
        chk("R5 write in stop ignored", int'(osc_en), 0);
        chk("R6 wdt in stop", int'(wdt_en), 0);
        pin_reset("R5 pin exit");

        // R5: power-on reset also leaves stop
        unlock();
        bus_write(CTRL, 8'h02);
        chk("R5 entered stop again", int'(osc_en), 0);
        por = 1'b1;
        idle(2);
        chk("R1 osc_en under por", int'(osc_en), 1);
        chk("R1 core_rst under por", int'(core_rst), 1);
        por = 1'b0;
        measure_hold("R5 por exit");

        // R9: reset raised mid-hold restarts the count
        ext_rst = 1'b1;
        idle(2);
        ext_rst = 1'b0;
        idle(HOLD / 2);
        chk("R9 still in first hold", int'(core_rst), 1);
        ext_rst = 1'b1;
        idle(1);
        ext_rst = 1'b0;
        measure_hold("R9 restart");

        // R10: writes during the hold are ignored
        ext_rst = 1'b1;
        idle(2);
        ext_rst = 1'b0;
        unlock();
        bus_write(CTRL, 8'h02);
        chk("R10 still in hold", int'(core_rst), 1);
        while (core_rst) @(negedge clk);
        chk("R10 hold write ignored", int'(osc_en), 1);
        bus_write(CTRL, 8'h02);
        chk("R10 no window left over", int'(osc_en), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule